// File: doc/BRIEF.md
# Escape-Fallback Virtual Channel Allocator

This block picks a downstream virtual channel for each packet head waiting at the input virtual channels of one router. Every output port offers a small set of adaptive channels and one escape channel. A packet in its adaptive phase may take any free adaptive channel on any output its routing logic marks as productive. A packet that cannot find any such channel for a set number of consecutive cycles is moved for good to the escape phase. From then on it may only take the escape channel on the single output chosen by dimension-order routing. Because escape routes follow dimension order, the escape channels always leave a deadlock-free way out.

The allocator keeps its own record of which downstream channels are in use. A channel is marked busy when it is granted and freed when the upstream logic reports that the packet's tail has left. Each requester selects exactly one candidate channel per cycle. Each output channel then grants at most one of its candidates in round-robin order. A phase bit per requester stays set until the packet completes. That bit is also given with each grant so that later hops keep the packet in escape mode. This runs ahead of switch allocation. The crossbar and the flit buffers sit outside the block.

Top module: `escape_vc_alloc`

## Requirements
- R1: After reset every output channel is free, no grant is raised and every requester is in the adaptive phase.
- R2: An adaptive requester is granted the first free adaptive channel in a scan over output ports in ascending order, considering only ports whose productive bit `req_prod_i[i*NUM_OUT+p]` is set, and within a port over adaptive channel numbers 0 to NUM_ADPT-1 in ascending order; `gnt_esc_o` is 0 for such a grant.
- R3: A requester whose header escape bit is set or whose phase is escape is offered only channel number NUM_ADPT on port `req_dor_i`; it gets no grant while that channel is busy, even if adaptive channels are free, and its grant carries `gnt_esc_o`=1.
- R4: Channel v of port p uses bit p*(NUM_ADPT+1)+v of `vc_busy_o`; the bit is set from the cycle after a grant, a busy channel is never granted, and a pulse on the same bit of `vc_release_i` frees it from the next cycle unless it is granted in that same cycle.
- R5: Each output channel grants at most one requester per cycle; among its candidates the first one after the previous winner in cyclic index order wins, and after reset requester 0 has first priority.
- R6: A valid adaptive requester with no free adaptive channel on any productive port for BLOCK_LIMIT consecutive cycles enters the escape phase from the following cycle; a cycle in which it is not valid or has a free adaptive channel restarts the count.
- R7: The escape phase holds until `pkt_done_i` for that requester is pulsed; the pulse wins over any cause for entering the escape phase and clears the blocked count.
- R8: A requester whose `req_valid_i` bit is low receives no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | NUM_REQ | Packet head waiting for a channel, per requester |
| req_esc_i | input | NUM_REQ | Escape bit carried in the arriving header |
| req_prod_i | input | NUM_REQ*NUM_OUT | Productive output ports, bit i*NUM_OUT+p |
| req_dor_i | input | NUM_REQ*PW | Dimension-order output port per requester |
| pkt_done_i | input | NUM_REQ | Tail left the input channel; resets the phase |
| vc_release_i | input | NUM_OUT*(NUM_ADPT+1) | Frees a downstream channel |
| gnt_o | output | NUM_REQ | Channel granted this cycle |
| gnt_port_o | output | NUM_REQ*PW | Output port of the grant |
| gnt_vc_o | output | NUM_REQ*VW | Channel number within the port |
| gnt_esc_o | output | NUM_REQ | Escape bit for the outgoing header |
| vc_busy_o | output | NUM_OUT*(NUM_ADPT+1) | Channel occupancy |

## Verification
On every cycle the checker confirms that grants only land on free channels, mark them busy and respect the pool rules. An escape grant must sit on the dimension-order port, and an adaptive grant must sit on a productive port. The checker also confirms that no output channel is handed out twice and that the escape phase only ends on a completion pulse. The exact choice of channel, the rotation of round-robin priority and the blocked-cycle count that triggers the fallback depend on history. Only the bench's reference model and its directed sequences can show these: full saturation of a port, a count broken one cycle short of the limit, and a fallback packet that refuses newly freed adaptive channels.

// File: rtl/vca_pkg.sv
package vca_pkg;
  typedef enum logic {PH_ADAPT = 1'b0, PH_ESC = 1'b1} phase_e;

  function automatic int unsigned clog2_min1(input int unsigned v);
    return (v <= 1) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/vca_phase_ctrl.sv
module vca_phase_ctrl
  import vca_pkg::*;
#(
  parameter int unsigned BLOCK_LIMIT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic hdr_esc_i,
  input  logic no_free_i,
  input  logic done_i,
  output logic phase_o
);
  localparam int unsigned CW = clog2_min1(BLOCK_LIMIT);

  phase_e         ph_q;
  logic [CW-1:0]  cnt_q;
  logic           stall;

  assign stall = valid_i && !hdr_esc_i && (ph_q == PH_ADAPT) && no_free_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_ADAPT;
      cnt_q <= '0;
    end else if (done_i) begin
      ph_q  <= PH_ADAPT;
      cnt_q <= '0;
    end else if (valid_i && hdr_esc_i) begin
      ph_q  <= PH_ESC;
      cnt_q <= '0;
    end else if (stall) begin
      if (cnt_q == CW'(BLOCK_LIMIT - 1)) begin
        ph_q  <= PH_ESC;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else begin
      cnt_q <= '0;
    end
  end

  assign phase_o = (ph_q == PH_ESC);
endmodule

// File: rtl/vca_target_sel.sv
module vca_target_sel
  import vca_pkg::*;
#(
  parameter int unsigned NUM_OUT  = 4,
  parameter int unsigned NUM_ADPT = 2,
  localparam int unsigned VPP = NUM_ADPT + 1,
  localparam int unsigned NVC = NUM_OUT * VPP,
  localparam int unsigned PW  = clog2_min1(NUM_OUT),
  localparam int unsigned VW  = clog2_min1(VPP),
  localparam int unsigned TW  = clog2_min1(NVC)
) (
  input  logic               valid_i,
  input  logic               esc_i,
  input  logic [NUM_OUT-1:0] prod_i,
  input  logic [PW-1:0]      dor_i,
  input  logic [NVC-1:0]     busy_i,
  output logic               tgt_vld_o,
  output logic [TW-1:0]      tgt_idx_o,
  output logic [PW-1:0]      tgt_port_o,
  output logic [VW-1:0]      tgt_vc_o,
  output logic               no_free_o
);
  logic          a_found;
  logic [TW-1:0] a_idx;
  logic [PW-1:0] a_port;
  logic [VW-1:0] a_vc;
  logic [TW-1:0] e_idx;
  logic          e_free;

  // port-major scan, lowest adaptive channel first
  always_comb begin
    a_found = 1'b0;
    a_idx   = '0;
    a_port  = '0;
    a_vc    = '0;
    for (int p = 0; p < NUM_OUT; p++) begin
      for (int v = 0; v < NUM_ADPT; v++) begin
        if (!a_found && prod_i[p] && !busy_i[p*VPP+v]) begin
          a_found = 1'b1;
          a_idx   = TW'(p*VPP + v);
          a_port  = PW'(p);
          a_vc    = VW'(v);
        end
      end
    end
  end

  assign e_idx  = TW'(int'(dor_i) * VPP + NUM_ADPT);
  assign e_free = !busy_i[e_idx];

  always_comb begin
    if (esc_i) begin
      tgt_vld_o  = valid_i && e_free;
      tgt_idx_o  = e_idx;
      tgt_port_o = dor_i;
      tgt_vc_o   = VW'(NUM_ADPT);
    end else begin
      tgt_vld_o  = valid_i && a_found;
      tgt_idx_o  = a_idx;
      tgt_port_o = a_port;
      tgt_vc_o   = a_vc;
    end
  end

  assign no_free_o = !a_found;
endmodule

// File: rtl/vca_rr_arb.sv
module vca_rr_arb
  import vca_pkg::*;
#(
  parameter int unsigned N = 4,
  localparam int unsigned IW = clog2_min1(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [IW-1:0] last_q;
  logic [IW-1:0] win;
  logic          hit;

  always_comb begin
    gnt_o = '0;
    hit   = 1'b0;
    win   = last_q;
    for (int k = 1; k <= N; k++) begin
      int c;
      c = (int'(last_q) + k) % N;
      if (!hit && req_i[c]) begin
        hit      = 1'b1;
        gnt_o[c] = 1'b1;
        win      = IW'(c);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  last_q <= IW'(N - 1);
    else if (hit) last_q <= win;
  end
endmodule

// File: rtl/escape_vc_alloc.sv
module escape_vc_alloc
  import vca_pkg::*;
#(
  parameter int unsigned NUM_REQ     = 4,
  parameter int unsigned NUM_OUT     = 4,
  parameter int unsigned NUM_ADPT    = 2,
  parameter int unsigned BLOCK_LIMIT = 4,
  localparam int unsigned VPP = NUM_ADPT + 1,
  localparam int unsigned NVC = NUM_OUT * VPP,
  localparam int unsigned PW  = clog2_min1(NUM_OUT),
  localparam int unsigned VW  = clog2_min1(VPP),
  localparam int unsigned TW  = clog2_min1(NVC)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_REQ-1:0]         req_valid_i,
  input  logic [NUM_REQ-1:0]         req_esc_i,
  input  logic [NUM_REQ*NUM_OUT-1:0] req_prod_i,
  input  logic [NUM_REQ*PW-1:0]      req_dor_i,
  input  logic [NUM_REQ-1:0]         pkt_done_i,
  input  logic [NVC-1:0]             vc_release_i,
  output logic [NUM_REQ-1:0]         gnt_o,
  output logic [NUM_REQ*PW-1:0]      gnt_port_o,
  output logic [NUM_REQ*VW-1:0]      gnt_vc_o,
  output logic [NUM_REQ-1:0]         gnt_esc_o,
  output logic [NVC-1:0]             vc_busy_o
);
  logic [NVC-1:0]     busy_q;
  logic [NVC-1:0]     gset;
  logic [NUM_REQ-1:0] phase_w;
  logic [NUM_REQ-1:0] esc_eff;
  logic [NUM_REQ-1:0] no_free;
  logic [NUM_REQ-1:0] tgt_vld;
  logic [TW-1:0]      tgt_idx  [NUM_REQ];
  logic [PW-1:0]      tgt_port [NUM_REQ];
  logic [VW-1:0]      tgt_vc   [NUM_REQ];
  logic [NUM_REQ-1:0] vc_req   [NVC];
  logic [NUM_REQ-1:0] vc_gnt   [NVC];

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
    vca_phase_ctrl #(.BLOCK_LIMIT(BLOCK_LIMIT)) u_phase (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .valid_i   (req_valid_i[i]),
      .hdr_esc_i (req_esc_i[i]),
      .no_free_i (no_free[i]),
      .done_i    (pkt_done_i[i]),
      .phase_o   (phase_w[i])
    );

    assign esc_eff[i] = phase_w[i] | (req_valid_i[i] & req_esc_i[i]);

    vca_target_sel #(.NUM_OUT(NUM_OUT), .NUM_ADPT(NUM_ADPT)) u_sel (
      .valid_i    (req_valid_i[i]),
      .esc_i      (esc_eff[i]),
      .prod_i     (req_prod_i[i*NUM_OUT +: NUM_OUT]),
      .dor_i      (req_dor_i[i*PW +: PW]),
      .busy_i     (busy_q),
      .tgt_vld_o  (tgt_vld[i]),
      .tgt_idx_o  (tgt_idx[i]),
      .tgt_port_o (tgt_port[i]),
      .tgt_vc_o   (tgt_vc[i]),
      .no_free_o  (no_free[i])
    );

    assign gnt_port_o[i*PW +: PW] = gnt_o[i] ? tgt_port[i] : '0;
    assign gnt_vc_o[i*VW +: VW]   = gnt_o[i] ? tgt_vc[i]   : '0;
    assign gnt_esc_o[i]           = gnt_o[i] & esc_eff[i];
  end

  for (genvar t = 0; t < NVC; t++) begin : g_vc
    always_comb begin
      for (int i = 0; i < NUM_REQ; i++)
        vc_req[t][i] = tgt_vld[i] && (tgt_idx[i] == TW'(t));
    end

    vca_rr_arb #(.N(NUM_REQ)) u_arb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (vc_req[t]),
      .gnt_o  (vc_gnt[t])
    );

    assign gset[t] = |vc_gnt[t];
  end

  always_comb begin
    gnt_o = '0;
    for (int t = 0; t < NVC; t++) gnt_o = gnt_o | vc_gnt[t];
  end

  // a grant wins over a release of the same channel
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= (busy_q & ~vc_release_i) | gset;
  end

  assign vc_busy_o = busy_q;
endmodule

// File: rtl/escape_vc_alloc_chk.sv
module escape_vc_alloc_chk
  import vca_pkg::*;
#(
  parameter int unsigned NUM_REQ  = 4,
  parameter int unsigned NUM_OUT  = 4,
  parameter int unsigned NUM_ADPT = 2,
  localparam int unsigned VPP = NUM_ADPT + 1,
  localparam int unsigned NVC = NUM_OUT * VPP,
  localparam int unsigned PW  = clog2_min1(NUM_OUT),
  localparam int unsigned VW  = clog2_min1(VPP),
  localparam int unsigned TW  = clog2_min1(NVC)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_REQ-1:0]         req_valid_i,
  input logic [NUM_REQ-1:0]         req_esc_i,
  input logic [NUM_REQ*NUM_OUT-1:0] req_prod_i,
  input logic [NUM_REQ*PW-1:0]      req_dor_i,
  input logic [NUM_REQ-1:0]         pkt_done_i,
  input logic [NVC-1:0]             vc_release_i,
  input logic [NUM_REQ-1:0]         gnt_o,
  input logic [NUM_REQ*PW-1:0]      gnt_port_o,
  input logic [NUM_REQ*VW-1:0]      gnt_vc_o,
  input logic [NUM_REQ-1:0]         gnt_esc_o,
  input logic [NVC-1:0]             vc_busy_o,
  input logic [NUM_REQ-1:0]         phase_i
);
  logic [TW-1:0]      gidx [NUM_REQ];
  logic [NUM_REQ-1:0] hits [NVC];

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_r
    assign gidx[i] = TW'(int'(gnt_port_o[i*PW +: PW]) * VPP + int'(gnt_vc_o[i*VW +: VW]));

    AST_GNT_ON_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_o[i] |-> !vc_busy_o[gidx[i]]); // R4
    AST_GNT_MARKS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_o[i] |=> vc_busy_o[$past(gidx[i])]); // R4
    AST_ESC_ON_DOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_o[i] && gnt_esc_o[i]) |->
        (int'(gnt_vc_o[i*VW +: VW]) == NUM_ADPT) && (gnt_port_o[i*PW +: PW] == req_dor_i[i*PW +: PW])); // R3
    AST_HDR_ESC_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_o[i] && req_esc_i[i]) |-> gnt_esc_o[i]); // R3
    AST_ADPT_PRODUCTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gnt_o[i] && !gnt_esc_o[i]) |->
        (int'(gnt_vc_o[i*VW +: VW]) < NUM_ADPT) && req_prod_i[i*NUM_OUT + int'(gnt_port_o[i*PW +: PW])]); // R2
    AST_PHASE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (phase_i[i] && !pkt_done_i[i]) |=> phase_i[i]); // R7
    AST_DONE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pkt_done_i[i] |=> !phase_i[i]); // R7
    AST_GNT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      gnt_o[i] |-> req_valid_i[i]); // R8
  end

  for (genvar t = 0; t < NVC; t++) begin : g_t
    always_comb begin
      for (int i = 0; i < NUM_REQ; i++) hits[t][i] = gnt_o[i] && (gidx[i] == TW'(t));
    end

    AST_ONE_GNT_PER_VC: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(hits[t]) <= 1); // R5
    AST_RELEASE_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vc_release_i[t] && (hits[t] == '0)) |=> !vc_busy_o[t]); // R4
  end
endmodule

bind escape_vc_alloc escape_vc_alloc_chk #(
  .NUM_REQ(NUM_REQ), .NUM_OUT(NUM_OUT), .NUM_ADPT(NUM_ADPT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_esc_i    (req_esc_i),
  .req_prod_i   (req_prod_i),
  .req_dor_i    (req_dor_i),
  .pkt_done_i   (pkt_done_i),
  .vc_release_i (vc_release_i),
  .gnt_o        (gnt_o),
  .gnt_port_o   (gnt_port_o),
  .gnt_vc_o     (gnt_vc_o),
  .gnt_esc_o    (gnt_esc_o),
  .vc_busy_o    (vc_busy_o),
  .phase_i      (phase_w)
);

// File: tb/tb_escape_vc_alloc.sv
`timescale 1ns/1ps
module tb_escape_vc_alloc;
  localparam int NR = 4, NO = 4, NA = 2, LIM = 4;
  localparam int VPP = NA + 1, NVC = NO * VPP, PW = 2, VW = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [NR-1:0]    valid, hdr, done;
  logic [NR*NO-1:0] prod;
  logic [NR*PW-1:0] dor;
  logic [NVC-1:0]   rel;
  wire  [NR-1:0]    gnt, gesc;
  wire  [NR*PW-1:0] gport;
  wire  [NR*VW-1:0] gvc;
  wire  [NVC-1:0]   busy;

  escape_vc_alloc #(.NUM_REQ(NR), .NUM_OUT(NO), .NUM_ADPT(NA), .BLOCK_LIMIT(LIM)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(valid), .req_esc_i(hdr), .req_prod_i(prod),
    .req_dor_i(dor), .pkt_done_i(done), .vc_release_i(rel), .gnt_o(gnt), .gnt_port_o(gport),
    .gnt_vc_o(gvc), .gnt_esc_o(gesc), .vc_busy_o(busy));

  int m_busy[NVC], m_last[NVC], m_ph[NR], m_cnt[NR];
  int e_win[NVC], e_tgt[NR], e_esc[NR], e_nofree[NR];
  int a_gnt[NR], a_esc[NR];
  int errs = 0, checks = 0;
  string tag = "R1";

  function automatic void m_reset();
    for (int t = 0; t < NVC; t++) begin m_busy[t] = 0; m_last[t] = NR - 1; end
    for (int i = 0; i < NR; i++) begin m_ph[i] = 0; m_cnt[i] = 0; end
  endfunction

  function automatic void m_eval();
    for (int i = 0; i < NR; i++) begin
      int af;
      af = -1;
      e_esc[i] = (m_ph[i] != 0 || (valid[i] && hdr[i])) ? 1 : 0;
      e_tgt[i] = -1;
      for (int p = 0; p < NO; p++)
        for (int v = 0; v < NA; v++)
          if (af < 0 && prod[i*NO+p] && m_busy[p*VPP+v] == 0) af = p*VPP + v;
      e_nofree[i] = (af < 0) ? 1 : 0;
      if (valid[i]) begin
        if (e_esc[i] != 0) begin
          int t;
          t = int'(dor[i*PW +: PW]) * VPP + NA;
          if (m_busy[t] == 0) e_tgt[i] = t;
        end else e_tgt[i] = af;
      end
    end
    for (int t = 0; t < NVC; t++) begin
      e_win[t] = -1;
      for (int k = 1; k <= NR; k++) begin
        int c;
        c = (m_last[t] + k) % NR;
        if (e_win[t] < 0 && e_tgt[c] == t) e_win[t] = c;
      end
    end
  endfunction

  function automatic void m_update();
    for (int t = 0; t < NVC; t++) begin
      if (e_win[t] >= 0) m_last[t] = e_win[t];
      m_busy[t] = ((m_busy[t] != 0 && !rel[t]) || e_win[t] >= 0) ? 1 : 0;
    end
    for (int i = 0; i < NR; i++) begin
      if (done[i]) begin m_ph[i] = 0; m_cnt[i] = 0; end
      else if (valid[i] && hdr[i]) begin m_ph[i] = 1; m_cnt[i] = 0; end
      else if (valid[i] && m_ph[i] == 0 && e_nofree[i] != 0) begin
        if (m_cnt[i] == LIM - 1) begin m_ph[i] = 1; m_cnt[i] = 0; end
        else m_cnt[i]++;
      end else m_cnt[i] = 0;
    end
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    int bexp;
    #1;
    m_eval();
    bexp = 0;
    for (int t = 0; t < NVC; t++) bexp |= (m_busy[t] << t);
    chk("vc_busy_o", int'(busy), bexp);
    for (int i = 0; i < NR; i++) begin
      int wt;
      wt = -1;
      for (int t = 0; t < NVC; t++) if (e_win[t] == i) wt = t;
      a_gnt[i] = int'(gnt[i]);
      a_esc[i] = int'(gesc[i]);
      chk($sformatf("gnt_o[%0d]", i), a_gnt[i], (wt >= 0) ? 1 : 0);
      if (wt >= 0) begin
        chk($sformatf("gnt_port_o[%0d]", i), int'(gport[i*PW +: PW]), wt / VPP);
        chk($sformatf("gnt_vc_o[%0d]", i), int'(gvc[i*VW +: VW]), wt % VPP);
        chk($sformatf("gnt_esc_o[%0d]", i), a_esc[i], e_esc[i]);
      end
    end
    m_update();
    @(posedge clk);
    @(negedge clk);
    rel  = '0;
    done = '0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    valid = '0; hdr = '0; done = '0; prod = '0; dor = '0; rel = '0;
    m_reset();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic set_req(input int i, input logic v, input logic h, input logic [NO-1:0] pm, input int d);
    valid[i] = v;
    hdr[i]   = h;
    prod[i*NO +: NO] = pm;
    dor[i*PW +: PW]  = PW'(d);
  endtask

  initial begin
    #800000;
    errs++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    do_reset();
    tag = "R1";
    #1;
    chk("vc_busy_o after reset", int'(busy), 0);
    chk("gnt_o after reset", int'(gnt), 0);
    tick();

    tag = "R2";
    set_req(0, 1, 0, 4'b0110, 1);
    tick();
    chk("port of first adaptive grant", int'(gport[1:0]), 1);

    tag = "R4";
    set_req(0, 0, 0, 4'b0, 0);
    set_req(1, 1, 0, 4'b0010, 1);
    tick();
    tick();
    chk("no grant with port saturated", a_gnt[1], 0);
    rel[3] = 1'b1;
    tick();
    tick();
    chk("grant after release", a_gnt[1], 1);
    set_req(1, 0, 0, 4'b0, 0);

    tag = "R5";
    for (int n = 0; n < 6; n++) begin
      for (int i = 0; i < 3; i++) set_req(i, 1, 0, 4'b1000, 0);
      rel[9] = 1'b1;
      rel[10] = 1'b1;
      tick();
    end
    valid = '0;

    tag = "R3";
    set_req(2, 1, 1, 4'b1111, 2);
    tick();
    chk("escape grant flag", a_esc[2], 1);
    set_req(2, 1, 1, 4'b1111, 2);
    tick();
    chk("no grant while escape busy", a_gnt[2], 0);
    valid = '0;
    done[2] = 1'b1;
    tick();

    tag = "R6";
    do_reset();
    set_req(0, 1, 0, 4'b0001, 0);
    tick();
    tick();
    set_req(0, 0, 0, 4'b0, 0);
    set_req(1, 1, 0, 4'b0001, 0);
    for (int n = 0; n < LIM; n++) begin
      tick();
      chk("blocked, no grant", a_gnt[1], 0);
    end
    tick();
    chk("fallback grant is escape", a_esc[1], 1);

    tag = "R7";
    rel[0] = 1'b1;
    tick();
    tick();
    chk("escape phase ignores free adaptive", a_gnt[1], 0);
    set_req(1, 0, 0, 4'b0001, 0);
    done[1] = 1'b1;
    tick();
    set_req(1, 1, 0, 4'b0001, 0);
    tick();
    chk("adaptive again after done", a_esc[1], 0);
    set_req(1, 0, 0, 4'b0, 0);

    tag = "R6";
    do_reset();
    set_req(0, 1, 0, 4'b0001, 0);
    tick();
    tick();
    set_req(0, 0, 0, 4'b0, 0);
    set_req(1, 1, 0, 4'b0001, 0);
    tick();
    tick();
    rel[1] = 1'b1;
    tick();
    tick();
    chk("count broken short of limit stays adaptive", a_esc[1], 0);
    chk("grant after short block", a_gnt[1], 1);

    tag = "R8";
    do_reset();
    set_req(0, 0, 0, 4'b1111, 0);
    set_req(1, 0, 1, 4'b1111, 1);
    tick();
    chk("no grant without valid", int'(a_gnt[0] + a_gnt[1]), 0);

    tag = "R2,R3,R5";
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < NR; i++) begin
        valid[i] = ($urandom % 2) == 0;
        hdr[i]   = ($urandom % 10) == 0;
        done[i]  = ($urandom % 16) == 0;
        prod[i*NO +: NO] = NO'($urandom);
        dor[i*PW +: PW]  = PW'($urandom);
      end
      if (($urandom % 10) < 5) rel = NVC'(1) << ($urandom % NVC);
      tick();
    end

    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule